// File: doc/BRIEF.md
# PCIe Host Interrupt Aggregator

This block collects the interrupt events that reach a PCIe root-complex wrapper and presents them to the host as separate interrupt outputs. There are three kinds of source. Inbound message-signalled interrupts arrive as a vector number on a valid strobe. Four legacy INTx lines arrive as levels. Six error events arrive as pulses. Each event is latched into a status register. Software masks sources through separate enable-set and enable-clear registers. An interrupt is acknowledged by writing ones back to the status bits that were seen.

The 32 message vectors are spread over eight groups. Vector v lands in group v mod 8 at status bit v div 8. Each group and each INTx line has its own output. That output gives a one-cycle pulse when an enabled status bit is pending, then stays quiet until software writes the source's code to the end-of-interrupt register. The error output is a plain registered level: the OR of error status AND error enable. Register access is a simple 32-bit bus. A read returns data one cycle after the read strobe.

Top module: `pcie_irq_hub`

## Requirements
- R1: A message with vector v sets bit (v >> 3) of group (v mod 8). The status of group n is read at 0x104+16n, so group 0 bits 0..3 hold vectors 0, 8, 16 and 24.
- R2: A write to any status address clears exactly the bits written as one. Bits written as zero keep their value.
- R3: If a message sets a status bit in the same cycle that a write-1-clear targets that bit, the bit ends up set.
- R4: The enables reset to zero. For group n, a write to 0x108+16n ORs the data into the enable mask and a write to 0x10C+16n clears the bits written as one. A read of either address returns the current mask.
- R5: A group output rises one cycle after an enabled status bit becomes pending, stays high for exactly one cycle, and then stays low until that group receives its end-of-interrupt code. A pending bit that is not enabled never raises the output.
- R6: Writing code n+4 to the end-of-interrupt register at 0x020 re-arms group n. The output pulses again on the following cycle if enabled bits are still pending. Any other code leaves group n quiet.
- R7: INTx line n is latched while its input is high into bit 0 of 0x184+16n. Its enable is set at 0x188+16n and cleared at 0x18C+16n. Its output follows the pulse and re-arm rules of R5 and R6, using end-of-interrupt code n (lines A..D map to codes 0..3).
- R8: Error status at 0x1C4 holds bit 0 system, bit 1 fatal, bit 2 non-fatal, bit 3 correctable, bit 4 tag-lookup fatal and bit 5 ECRC. Writing back the value that was read clears it. The enable is set at 0x1C8 and cleared at 0x1CC. The error output is the registered OR of status AND enable.
- R9: After reset, every output is low and every status and enable register reads zero.
- R10: Read data is zero in any cycle not following a read strobe, and a read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| msi_valid | input | 1 | Inbound message interrupt strobe |
| msi_vector | input | 5 | Vector number carried by the message |
| intx_in | input | 4 | Legacy INTx levels, lines A..D |
| err_evt | input | 6 | Error event pulses |
| msi_irq | output | 8 | Per-group host interrupt pulses |
| intx_irq | output | 4 | Per-line host interrupt pulses |
| err_irq | output | 1 | Error host interrupt level |

## Verification
Vectors 0, 8, 13 and 31 are sent to check that group and bit steering are not swapped. Vector 31 hits the highest group and bit at once. The tests cover a masked pending bit, an acknowledged bit and an unacknowledged bit followed by end-of-interrupt. Together these separate the pulse-and-re-arm behaviour from a plain level output, and show a foreign end-of-interrupt code doing nothing. A message that meets a clear in the same cycle shows that set wins. The error tests enable a subset of bits, which shows that a masked error cannot reach the output and that writing back the read value clears everything.

// File: rtl/pcie_irq_hub_pkg.sv
`timescale 1ns/1ps
package pcie_irq_hub_pkg;
  localparam int ADDR_W     = 12;
  localparam int REG_STRIDE = 16;
  // Offsets that software decodes directly.
  localparam logic [ADDR_W-1:0] MSI_STAT_BASE  = 12'h104;
  localparam logic [ADDR_W-1:0] INTX_STAT_BASE = 12'h184;
  localparam logic [ADDR_W-1:0] ERR_STAT_ADDR  = 12'h1C4;
  localparam logic [ADDR_W-1:0] ERR_ENS_ADDR   = 12'h1C8;
  localparam logic [ADDR_W-1:0] ERR_ENC_ADDR   = 12'h1CC;
  localparam logic [ADDR_W-1:0] EOI_ADDR       = 12'h020;
  localparam logic [ADDR_W-1:0] EN_SET_OFS     = 12'h004;
  localparam logic [ADDR_W-1:0] EN_CLR_OFS     = 12'h008;
endpackage

// File: rtl/msi_vec_steer.sv
`timescale 1ns/1ps
// Spreads a vector number over groups: vector v -> group v mod GROUPS, bit v / GROUPS (R1).
module msi_vec_steer #(
  parameter int GROUPS = 8,
  parameter int BITS   = 4,
  parameter int VEC_W  = 5
) (
  input  logic                         valid,
  input  logic [VEC_W-1:0]             vector,
  output logic [GROUPS-1:0][BITS-1:0]  set
);
  always_comb begin
    set = '0;
    for (int g = 0; g < GROUPS; g++) begin
      for (int b = 0; b < BITS; b++) begin
        if (valid && vector == VEC_W'(b * GROUPS + g)) set[g][b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_src_bank.sv
`timescale 1ns/1ps
// One interrupt source bank: sticky status, enable mask, and either a
// re-armed pulse output (REARM=1) or a level output (REARM=0).
module irq_src_bank #(
  parameter int W     = 4,
  parameter bit REARM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_set,
  input  logic         stat_wr,
  input  logic [W-1:0] stat_clr,
  input  logic         en_set_wr,
  input  logic         en_clr_wr,
  input  logic [W-1:0] en_data,
  input  logic         eoi,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         irq
);
  logic pend;
  assign pend = |(status & enable);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
    end else begin
      // new events win over a clear of the same bit (R3)
      status <= (status & ~(stat_wr ? stat_clr : {W{1'b0}})) | evt_set;
      if (en_set_wr)      enable <= enable | en_data;
      else if (en_clr_wr) enable <= enable & ~en_data;
    end
  end

  generate
    if (REARM) begin : g_pulse
      logic armed;
      always_ff @(posedge clk) begin
        if (rst) begin
          armed <= 1'b1;
          irq   <= 1'b0;
        end else begin
          irq   <= armed & pend;                 // R5
          armed <= eoi | (armed & ~pend);        // R6
        end
      end
    end else begin : g_level
      logic unused_eoi;
      assign unused_eoi = eoi;
      always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pend;                    // R8
      end
    end
  endgenerate
endmodule

// File: rtl/pcie_irq_hub.sv
`timescale 1ns/1ps
module pcie_irq_hub
  import pcie_irq_hub_pkg::*;
#(
  parameter int MSI_GROUPS = 8,
  parameter int MSI_BITS   = 4,
  parameter int INTX_LINES = 4,
  parameter int ERR_BITS   = 6,
  parameter int VEC_W      = $clog2(MSI_GROUPS * MSI_BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  msi_valid,
  input  logic [VEC_W-1:0]      msi_vector,
  input  logic [INTX_LINES-1:0] intx_in,
  input  logic [ERR_BITS-1:0]   err_evt,
  output logic [MSI_GROUPS-1:0] msi_irq,
  output logic [INTX_LINES-1:0] intx_irq,
  output logic                  err_irq
);
  logic [MSI_GROUPS-1:0][MSI_BITS-1:0] msi_set, msi_stat, msi_en;
  logic [INTX_LINES-1:0]               intx_stat, intx_en;
  logic [ERR_BITS-1:0]                 err_stat, err_en;
  logic                                eoi_wr;
  logic [31:0]                         rd_mux;

  assign eoi_wr = reg_wr && (reg_addr == EOI_ADDR);

  msi_vec_steer #(.GROUPS(MSI_GROUPS), .BITS(MSI_BITS), .VEC_W(VEC_W)) u_steer (
    .valid(msi_valid), .vector(msi_vector), .set(msi_set));

  // Message groups: end-of-interrupt code INTX_LINES+g (R6)
  for (genvar g = 0; g < MSI_GROUPS; g++) begin : g_msi
    localparam logic [ADDR_W-1:0] A_ST = MSI_STAT_BASE + ADDR_W'(g * REG_STRIDE);
    irq_src_bank #(.W(MSI_BITS), .REARM(1'b1)) u_bank (
      .clk(clk), .rst(rst),
      .evt_set(msi_set[g]),
      .stat_wr(reg_wr && reg_addr == A_ST),
      .stat_clr(reg_wdata[MSI_BITS-1:0]),
      .en_set_wr(reg_wr && reg_addr == A_ST + EN_SET_OFS),
      .en_clr_wr(reg_wr && reg_addr == A_ST + EN_CLR_OFS),
      .en_data(reg_wdata[MSI_BITS-1:0]),
      .eoi(eoi_wr && reg_wdata == 32'(INTX_LINES + g)),
      .status(msi_stat[g]), .enable(msi_en[g]), .irq(msi_irq[g]));
  end

  // Legacy lines: end-of-interrupt code i (R7)
  for (genvar i = 0; i < INTX_LINES; i++) begin : g_intx
    localparam logic [ADDR_W-1:0] A_ST = INTX_STAT_BASE + ADDR_W'(i * REG_STRIDE);
    irq_src_bank #(.W(1), .REARM(1'b1)) u_bank (
      .clk(clk), .rst(rst),
      .evt_set(intx_in[i]),
      .stat_wr(reg_wr && reg_addr == A_ST),
      .stat_clr(reg_wdata[0]),
      .en_set_wr(reg_wr && reg_addr == A_ST + EN_SET_OFS),
      .en_clr_wr(reg_wr && reg_addr == A_ST + EN_CLR_OFS),
      .en_data(reg_wdata[0]),
      .eoi(eoi_wr && reg_wdata == 32'(i)),
      .status(intx_stat[i]), .enable(intx_en[i]), .irq(intx_irq[i]));
  end

  // Errors: level output, no re-arm (R8)
  irq_src_bank #(.W(ERR_BITS), .REARM(1'b0)) u_err (
    .clk(clk), .rst(rst),
    .evt_set(err_evt),
    .stat_wr(reg_wr && reg_addr == ERR_STAT_ADDR),
    .stat_clr(reg_wdata[ERR_BITS-1:0]),
    .en_set_wr(reg_wr && reg_addr == ERR_ENS_ADDR),
    .en_clr_wr(reg_wr && reg_addr == ERR_ENC_ADDR),
    .en_data(reg_wdata[ERR_BITS-1:0]),
    .eoi(1'b0),
    .status(err_stat), .enable(err_en), .irq(err_irq));

  // Read decode (R4, R10)
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < MSI_GROUPS; g++) begin
      if (reg_addr == MSI_STAT_BASE + ADDR_W'(g * REG_STRIDE))
        rd_mux = 32'(msi_stat[g]);
      if (reg_addr == MSI_STAT_BASE + ADDR_W'(g * REG_STRIDE) + EN_SET_OFS ||
          reg_addr == MSI_STAT_BASE + ADDR_W'(g * REG_STRIDE) + EN_CLR_OFS)
        rd_mux = 32'(msi_en[g]);
    end
    for (int i = 0; i < INTX_LINES; i++) begin
      if (reg_addr == INTX_STAT_BASE + ADDR_W'(i * REG_STRIDE))
        rd_mux = 32'(intx_stat[i]);
      if (reg_addr == INTX_STAT_BASE + ADDR_W'(i * REG_STRIDE) + EN_SET_OFS ||
          reg_addr == INTX_STAT_BASE + ADDR_W'(i * REG_STRIDE) + EN_CLR_OFS)
        rd_mux = 32'(intx_en[i]);
    end
    if (reg_addr == ERR_STAT_ADDR) rd_mux = 32'(err_stat);
    if (reg_addr == ERR_ENS_ADDR || reg_addr == ERR_ENC_ADDR) rd_mux = 32'(err_en);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= '0;
  end
endmodule

// File: rtl/pcie_irq_hub_chk.sv
`timescale 1ns/1ps
module pcie_irq_hub_chk
  import pcie_irq_hub_pkg::*;
#(
  parameter int MSI_GROUPS = 8,
  parameter int INTX_LINES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [31:0]           reg_wdata,
  input logic [31:0]           reg_rdata,
  input logic [MSI_GROUPS-1:0] msi_irq,
  input logic [INTX_LINES-1:0] intx_irq,
  input logic                  err_irq
);
  logic eoi_wr;
  assign eoi_wr = reg_wr && reg_addr == EOI_ADDR;

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (msi_irq == '0 && intx_irq == '0 && !err_irq)); // R9

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd) |-> reg_rdata == '0); // R10

  for (genvar g = 0; g < MSI_GROUPS; g++) begin : g_msi
    logic hit;
    assign hit = eoi_wr && reg_wdata == 32'(INTX_LINES + g);
    AST_MSI_WAITS_EOI: assert property (@(posedge clk) disable iff (rst)
      ($past(msi_irq[g]) && !$past(hit, 2)) |-> !msi_irq[g]); // R5
  end

  for (genvar i = 0; i < INTX_LINES; i++) begin : g_intx
    logic hit;
    assign hit = eoi_wr && reg_wdata == 32'(i);
    AST_INTX_WAITS_EOI: assert property (@(posedge clk) disable iff (rst)
      ($past(intx_irq[i]) && !$past(hit, 2)) |-> !intx_irq[i]); // R7
  end
endmodule

bind pcie_irq_hub pcie_irq_hub_chk #(.MSI_GROUPS(MSI_GROUPS), .INTX_LINES(INTX_LINES)) u_chk (.*);

// File: tb/pcie_irq_hub_test.sv
`timescale 1ns/1ps
module pcie_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_valid = 1'b0;
  logic [4:0]  msi_vector = '0;
  logic [3:0]  intx_in = '0;
  logic [5:0]  err_evt = '0;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;
  logic        err_irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pcie_irq_hub uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic msi(logic [4:0] v);
    @(negedge clk); msi_valid = 1'b1; msi_vector = v;
    @(negedge clk); msi_valid = 1'b0;
  endtask

  // kind 0: message group, 1: INTx line, 2: error level
  task automatic count_hi(int kind, int idx, int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (kind == 0 && msi_irq[idx]) n++;
      if (kind == 1 && intx_irq[idx]) n++;
      if (kind == 2 && err_irq) n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 outputs after reset", {19'd0, msi_irq, intx_irq, err_irq}, 32'h0);
    rd(12'h104, d); check("R9 group0 status", d, 0);
    rd(12'h108, d); check("R9 group0 enable", d, 0);
    rd(12'h1C8, d); check("R9 error enable", d, 0);
  endtask

  task automatic t_steer();
    logic [31:0] d;
    int n;
    msi(5'd0); msi(5'd8); msi(5'd13); msi(5'd31);
    count_hi(0, 0, 4, n); check("R5 masked pending no pulse", n, 0);
    rd(12'h104, d); check("R1 group0 holds vectors 0,8", d, 32'h3);
    rd(12'h154, d); check("R1 group5 holds vector 13", d, 32'h2);
    rd(12'h174, d); check("R1 group7 holds vector 31", d, 32'h8);
    wr(12'h104, 32'h2);
    rd(12'h104, d); check("R2 clears only written ones", d, 32'h1);
    wr(12'h104, 32'h1); wr(12'h154, 32'h2); wr(12'h174, 32'h8);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    msi(5'd2);
    @(negedge clk); msi_valid = 1'b1; msi_vector = 5'd2;
    reg_wr = 1'b1; reg_addr = 12'h124; reg_wdata = 32'h1;
    @(negedge clk); msi_valid = 1'b0; reg_wr = 1'b0;
    rd(12'h124, d); check("R3 set wins over clear", d, 32'h1);
    wr(12'h124, 32'h1);
    rd(12'h124, d); check("R2 plain clear", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(12'h138, 32'h6);
    wr(12'h13C, 32'h4);
    rd(12'h138, d); check("R4 mask via set address", d, 32'h2);
    rd(12'h13C, d); check("R4 mask via clear address", d, 32'h2);
  endtask

  task automatic t_pulse_eoi();
    int n;
    msi(5'd11);                      // group 3, bit 1, enabled
    count_hi(0, 3, 6, n); check("R5 single pulse", n, 1);
    wr(12'h020, 32'd7);
    count_hi(0, 3, 6, n); check("R6 re-fire after EOI with pending", n, 1);
    wr(12'h134, 32'h2);
    wr(12'h020, 32'd7);
    count_hi(0, 3, 6, n); check("R6 EOI with nothing pending", n, 0);
    msi(5'd11);
    count_hi(0, 3, 6, n); check("R6 still armed fires", n, 1);
    wr(12'h020, 32'd4);
    count_hi(0, 3, 6, n); check("R6 foreign code no re-arm", n, 0);
    wr(12'h134, 32'h2);
    wr(12'h020, 32'd7);
  endtask

  task automatic t_intx();
    logic [31:0] d;
    int n;
    wr(12'h198, 32'h1);
    @(negedge clk); intx_in[1] = 1'b1;
    count_hi(1, 1, 6, n); check("R7 line B single pulse", n, 1);
    intx_in[1] = 1'b0;
    rd(12'h194, d); check("R7 line B status", d, 32'h1);
    wr(12'h020, 32'd1);
    count_hi(1, 1, 6, n); check("R7 EOI code 1 re-fires", n, 1);
    wr(12'h194, 32'h1);
    rd(12'h194, d); check("R7 line B cleared", d, 32'h0);
    wr(12'h19C, 32'h1);
    rd(12'h198, d); check("R7 line B enable cleared", d, 32'h0);
  endtask

  task automatic t_err();
    logic [31:0] d;
    int n;
    wr(12'h1C8, 32'h24);               // non-fatal and ECRC enabled
    @(negedge clk); err_evt = 6'h01;   // system error, masked
    @(negedge clk); err_evt = 6'h00;
    count_hi(2, 0, 3, n); check("R8 masked error no output", n, 0);
    @(negedge clk); err_evt = 6'h20;   // ECRC
    @(negedge clk); err_evt = 6'h00;
    count_hi(2, 0, 3, n); check("R8 enabled error holds level", n, 3);
    rd(12'h1C4, d); check("R8 error status bits 0 and 5", d, 32'h21);
    wr(12'h1C4, d);
    rd(12'h1C4, d); check("R8 write-back clears", d, 32'h0);
    count_hi(2, 0, 2, n); check("R8 output drops", n, 0);
    wr(12'h1CC, 32'h04);
    rd(12'h1C8, d); check("R8 enable after clear", d, 32'h20);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h000, d); check("R10 unmapped reads zero", d, 0);
    @(negedge clk); check("R10 idle read data zero", reg_rdata, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_steer();
    t_collide();
    t_enable();
    t_pulse_eoi();
    t_intx();
    t_err();
    t_unmapped();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule